// File: doc/BRIEF.md
# Overcurrent Fault Hiccup Sequencer

This block is the digital fault manager of a switching-regulator controller. Once per switching cycle it receives a one-clock strobe and an overcurrent flag. It keeps a saturating up/down tally of overcurrent cycles. When the tally fills, it declares a fault. It then forces the high-side switch off and the low-side switch on, and runs a hiccup recovery. The recovery uses repeated discharge and recharge of the external soft-start capacitor. Each recharge to the threshold removes one count from the tally. When the tally is empty, the controller restarts with a full soft-start.

The soft-start capacitor and its comparators are outside the block. They are seen only as three flags: capacitor empty, capacitor reached the recovery threshold, and soft-start ramp passed the reference. Overcurrent events are tallied only after the soft-start ramp has passed the reference. A shutdown input takes precedence over every phase of operation.

Top module: `ocp_hiccup`

## Requirements
- R1: After a synchronous reset the outputs are fault=0, hs_en_o=1, ls_force_o=0, ss_dis_o=0 and count_en_o=0 (soft-start phase). The tally is 0.
- R2: In the soft-start phase, strobes carrying an overcurrent flag do not change the tally. A cycle with ss_ref_i high moves the block to the run phase, where count_en_o=1.
- R3: In the run phase, each strobe adds one to the tally if oc_i is high and subtracts one otherwise. The strobe that would bring the tally to 7 (2^CNT_W-1) declares the fault instead; seven overcurrent strobes from an empty tally do this.
- R4: The tally saturates at 0. Extra strobes without overcurrent leave it at 0, so exactly seven overcurrent strobes are then still needed for a fault.
- R5: oc_i has no effect in a cycle without a strobe.
- R6: While the fault is declared: fault_o=1, hs_en_o=0, ls_force_o=1 and count_en_o=0. The high-side enable and the low-side force are never both high.
- R7: Declaring the fault removes one count (the tally goes to 6) and requests a discharge (ss_dis_o=1). ss_empty_i releases the request. ss_thr_i during recharge removes one count and requests a discharge again. When ss_empty_i arrives with the tally at 0, after six recharges, the fault clears and the block returns to the soft-start phase with the tally at 0.
- R8: Strobes and overcurrent flags during the fault do not change the number of recharges needed.
- R9: While shdn_i is high, hs_en_o, ls_force_o, fault_o and count_en_o are 0, from the next clock on. After release the block is in the reset state, whatever phase it was in.
- R10: ss_thr_i is ignored outside the recharge phase, and ss_empty_i is ignored outside the discharge phase.
- R11: A synchronous reset during a fault restores the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shdn_i | input | 1 | Shutdown, forces drives off and resets the sequence |
| cyc_stb_i | input | 1 | One-clock strobe per switching cycle |
| oc_i | input | 1 | Overcurrent seen in this switching cycle (sampled at the strobe) |
| ss_empty_i | input | 1 | Soft-start capacitor fully discharged |
| ss_thr_i | input | 1 | Soft-start capacitor reached the recovery threshold |
| ss_ref_i | input | 1 | Soft-start ramp passed the reference |
| fault_o | output | 1 | Fault declared |
| hs_en_o | output | 1 | High-side drive enable |
| ls_force_o | output | 1 | Force low-side switch on |
| ss_dis_o | output | 1 | Soft-start discharge request |
| count_en_o | output | 1 | Overcurrent tallying active (run phase) |

## Verification
On every cycle the assertions check the output relations:
- drive exclusivity and the fault drive pattern;
- that a discharge request appears only with a fault, and that tallying never coincides with a fault;
- that a fault rises only out of the run phase and falls back with the high side enabled;
- that shutdown blanks the drives.

The tally is not visible at the ports. Its arithmetic can only be shown by the bench scenarios:
- overcurrent strobe sweeps, saturation at zero, and a long pseudo-random strobe pattern checked against an arithmetic model;
- counting the exact number of recharges before restart;
- the ignored flags, shutdown and reset in mid-recovery, each followed by a fresh fault run that reveals the tally left behind.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    PH_SOFT   = 2'd0,
    PH_RUN    = 2'd1,
    PH_DRAIN  = 2'd2,
    PH_CHARGE = 2'd3
  } phase_e;

  typedef struct packed {
    logic fault;
    logic hs_en;
    logic ls_force;
    logic ss_dis;
    logic count_en;
  } drv_t;
endpackage

// File: rtl/ocp_tally.sv
module ocp_tally #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic             dec,
  output logic             near_full,
  output logic             empty
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (inc && !dec) begin
      if (cnt_q != TOP) cnt_q <= cnt_q + ONE;
    end else if (dec && !inc) begin
      if (cnt_q != '0) cnt_q <= cnt_q - ONE;
    end
  end

  assign near_full = (cnt_q == TOP - ONE);
  assign empty     = (cnt_q == '0);
endmodule

// File: rtl/ocp_seq.sv
module ocp_seq
  import ocp_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   shdn,
  input  logic   stb,
  input  logic   oc,
  input  logic   ss_empty,
  input  logic   ss_thr,
  input  logic   ss_ref,
  input  logic   near_full,
  input  logic   empty,
  output phase_e phase_n,
  output logic   inc,
  output logic   dec
);
  phase_e phase_q;

  always_comb begin
    phase_n = phase_q;
    inc     = 1'b0;
    dec     = 1'b0;
    if (shdn) begin
      phase_n = PH_SOFT;
    end else begin
      unique case (phase_q)
        PH_SOFT: begin
          if (ss_ref) phase_n = PH_RUN;
        end
        PH_RUN: begin
          if (stb) begin
            if (oc && near_full) begin
              // reaching full and the first discharge cancel out
              phase_n = PH_DRAIN;
            end else begin
              inc = oc;
              dec = !oc;
            end
          end
        end
        PH_DRAIN: begin
          if (ss_empty) phase_n = empty ? PH_SOFT : PH_CHARGE;
        end
        PH_CHARGE: begin
          if (ss_thr) begin
            dec     = 1'b1;
            phase_n = PH_DRAIN;
          end
        end
        default: phase_n = PH_SOFT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_SOFT;
    else     phase_q <= phase_n;
  end
endmodule

// File: rtl/ocp_hiccup.sv
module ocp_hiccup
  import ocp_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic shdn_i,
  input  logic cyc_stb_i,
  input  logic oc_i,
  input  logic ss_empty_i,
  input  logic ss_thr_i,
  input  logic ss_ref_i,
  output logic fault_o,
  output logic hs_en_o,
  output logic ls_force_o,
  output logic ss_dis_o,
  output logic count_en_o
);
  phase_e phase_n;
  logic   inc, dec, near_full, empty;
  drv_t   drv_n, drv_q;

  ocp_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst(rst), .clr(shdn_i), .inc(inc), .dec(dec),
    .near_full(near_full), .empty(empty)
  );

  ocp_seq u_seq (
    .clk(clk), .rst(rst), .shdn(shdn_i), .stb(cyc_stb_i), .oc(oc_i),
    .ss_empty(ss_empty_i), .ss_thr(ss_thr_i), .ss_ref(ss_ref_i),
    .near_full(near_full), .empty(empty),
    .phase_n(phase_n), .inc(inc), .dec(dec)
  );

  always_comb begin
    drv_n          = '0;
    drv_n.fault    = (phase_n == PH_DRAIN) || (phase_n == PH_CHARGE);
    drv_n.hs_en    = !shdn_i && !drv_n.fault;
    drv_n.ls_force = drv_n.fault;
    drv_n.ss_dis   = (phase_n == PH_DRAIN);
    drv_n.count_en = (phase_n == PH_RUN);
  end

  always_ff @(posedge clk) begin
    if (rst) drv_q <= '{fault: 1'b0, hs_en: 1'b1, ls_force: 1'b0, ss_dis: 1'b0, count_en: 1'b0};
    else     drv_q <= drv_n;
  end

  assign fault_o    = drv_q.fault;
  assign hs_en_o    = drv_q.hs_en;
  assign ls_force_o = drv_q.ls_force;
  assign ss_dis_o   = drv_q.ss_dis;
  assign count_en_o = drv_q.count_en;
endmodule

// File: rtl/ocp_hiccup_chk.sv
module ocp_hiccup_chk (
  input logic clk,
  input logic rst,
  input logic shdn_i,
  input logic fault_o,
  input logic hs_en_o,
  input logic ls_force_o,
  input logic ss_dis_o,
  input logic count_en_o
);
  // R6
  fault_drive_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> (!hs_en_o && ls_force_o && !count_en_o));
  // R6
  no_cross_chk: assert property (@(posedge clk) disable iff (rst)
    !(hs_en_o && ls_force_o));
  // R7
  dis_in_fault_chk: assert property (@(posedge clk) disable iff (rst)
    ss_dis_o |-> fault_o);
  // R9
  shdn_drive_chk: assert property (@(posedge clk) disable iff (rst)
    shdn_i |=> (!hs_en_o && !ls_force_o && !fault_o && !count_en_o));
  // R3
  fault_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_o) |-> $past(count_en_o));
  // R7
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_o) |-> (!count_en_o && (hs_en_o || $past(shdn_i))));
endmodule

bind ocp_hiccup ocp_hiccup_chk u_chk (
  .clk(clk), .rst(rst), .shdn_i(shdn_i), .fault_o(fault_o), .hs_en_o(hs_en_o),
  .ls_force_o(ls_force_o), .ss_dis_o(ss_dis_o), .count_en_o(count_en_o)
);

// File: tb/ocp_hiccup_test.sv
module ocp_hiccup_test;
  logic clk = 1'b0;
  logic rst = 1'b1, shdn = 1'b0, stb = 1'b0, oc = 1'b0, emp = 1'b0, thr = 1'b0, sref = 1'b0;
  logic fault, hs, ls, dis, cen;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  localparam logic [4:0] O_SOFT = 5'b01000, O_RUN = 5'b01001, O_DRAIN = 5'b10110,
                         O_CHG = 5'b10100, O_OFF = 5'b00000;

  always #5 clk = ~clk;

  ocp_hiccup uut (
    .clk(clk), .rst(rst), .shdn_i(shdn), .cyc_stb_i(stb), .oc_i(oc),
    .ss_empty_i(emp), .ss_thr_i(thr), .ss_ref_i(sref),
    .fault_o(fault), .hs_en_o(hs), .ls_force_o(ls), .ss_dis_o(dis), .count_en_o(cen)
  );

  task automatic step(input logic s, input logic o, input logic e, input logic t,
                      input logic r, input logic d);
    stb = s; oc = o; emp = e; thr = t; sref = r; shdn = d;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {fault, hs, ls, dis, cen};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    rst = 1'b0;
  endtask

  task automatic go_run();
    do_reset();
    step(0, 0, 0, 0, 1, 0);
  endtask

  // drive exactly seven overcurrent strobes, expecting the fault on the last
  task automatic drive_fault(input string req);
    for (int i = 1; i <= 7; i++) begin
      step(1, 1, 0, 0, 0, 0);
      chk(req, (i == 7) ? O_DRAIN : O_RUN);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    int m;
    @(negedge clk);
    do_reset();
    chk("R1 reset state", O_SOFT);

    // R2: strobes in soft-start are not tallied
    for (int i = 0; i < 10; i++) step(1, 1, 0, 0, 0, 0);
    chk("R2 soft-start ignores oc", O_SOFT);
    step(0, 0, 0, 0, 1, 0);
    chk("R2 run after ref", O_RUN);
    for (int i = 0; i < 6; i++) step(1, 1, 0, 0, 0, 0);
    chk("R2 tally empty after soft-start", O_RUN);

    // R3: sweep of overcurrent run length from empty tally
    for (int k = 1; k <= 7; k++) begin
      go_run();
      for (int i = 1; i <= k; i++) begin
        step(1, 1, 0, 0, 0, 0);
        chk("R3 oc run sweep", (i == 7) ? O_DRAIN : O_RUN);
      end
    end

    // R4: saturation at zero
    go_run();
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 0);
    drive_fault("R4 saturate at zero");

    // R3/R4/R5/R10: pseudo-random strobes against arithmetic model
    go_run();
    m = 0;
    lf = 16'hACE1;
    for (int it = 0; it < 400; it++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(0, 1, lf[3], lf[2], 0, 0);
      chk("R5 R10 no-strobe cycle", O_RUN);
      if (m == 6 && (lf[0] | lf[1])) begin
        step(1, 1, 0, 0, 0, 0);
        chk("R3 model fault", O_DRAIN);
        go_run();
        m = 0;
      end else begin
        step(1, lf[0] | lf[1], 0, 0, 0, 0);
        if (lf[0] | lf[1]) m = m + 1;
        else if (m > 0) m = m - 1;
        chk("R3 R4 model run", O_RUN);
      end
    end

    // R6 R7 R8 R10: full recovery sequence
    go_run();
    drive_fault("R6 fault entry");
    chk("R6 fault drive pattern", O_DRAIN);
    step(0, 0, 0, 1, 0, 0);
    chk("R10 thr ignored while draining", O_DRAIN);
    step(1, 1, 0, 0, 0, 0);
    chk("R8 strobe ignored in fault", O_DRAIN);
    step(0, 0, 1, 0, 0, 0);
    chk("R7 empty releases discharge", O_CHG);
    for (int i = 1; i <= 6; i++) begin
      step(0, 0, 1, 0, 0, 0);
      chk("R10 empty ignored while charging", O_CHG);
      step(1, 1, 0, 0, 1, 0);
      chk("R8 strobe and ref ignored in fault", O_CHG);
      step(0, 0, 0, 1, 0, 0);
      chk("R7 threshold requests discharge", O_DRAIN);
      step(0, 0, 1, 0, 0, 0);
      chk("R7 recharge count", (i == 6) ? O_SOFT : O_CHG);
    end
    step(0, 0, 0, 0, 1, 0);
    chk("R7 run after restart", O_RUN);
    drive_fault("R7 tally empty after recovery");

    // R9: shutdown mid-recovery
    step(0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    chk("R9 mid-recovery before shutdown", O_CHG);
    step(0, 0, 0, 0, 0, 1);
    chk("R9 shutdown drives off", O_OFF);
    step(1, 1, 1, 1, 1, 1);
    chk("R9 shutdown holds", O_OFF);
    step(0, 0, 0, 0, 0, 0);
    chk("R9 released to soft-start", O_SOFT);
    step(0, 0, 0, 0, 1, 0);
    drive_fault("R9 tally cleared by shutdown");

    // R11: reset in mid-fault
    do_reset();
    chk("R11 reset during fault", O_SOFT);
    step(0, 0, 0, 0, 1, 0);
    drive_fault("R11 tally cleared by reset");

    finish_run();
  end
endmodule